// File: doc/BRIEF.md
# Xon/Xoff Software Flow Controller

This block carries out software flow control for a single UART channel. It watches the received byte stream for programmed stop and resume characters. In single-character mode one byte makes a match. In pair mode a match needs two consecutive received bytes. A stop match halts the transmitter once the character currently on the wire has finished. A resume match, seen while the transmitter is halted, lets it run again. The match logic does not consume matched bytes, so they still reach the receive FIFO.

A separate part of the block watches the receive FIFO fill level against a high and a low threshold. When the fill level crosses one of them, it asks the transmitter to send a stop or a resume character. Each request is a single-cycle pulse. It is issued once per crossing, and never while a character is being transmitted. The thresholds must hold their final values before `sw_en` is raised.

Top module: `sfc_top`

## Requirements
- R1: The four character registers reset to 0x00 and are written through `cfg_we`/`cfg_sel`/`cfg_wdata`. Select 0 is the first resume character, 1 is the second resume character, 2 is the first stop character and 3 is the second stop character. Straight after reset, a received 0x00 therefore matches as a stop character.
- R2: With `pair_mode`=0, a received byte equal to the first stop character suspends the transmitter. A received byte equal to the first resume character resumes it, but only while suspended. When a byte matches both, the stop match wins.
- R3: `tx_enable` falls on the first clock edge at or after the stop match on which `tx_active` is low. It never falls while a character is in flight.
- R4: With `pair_mode`=1, a match needs the first value and then the second value on two back-to-back received bytes. Any other byte in between restarts the sequence. A second value with no first value before it has no effect.
- R5: A stop match sets `xoff_flag` when `flag_en`=1. `irq` is high exactly when `xoff_flag` and `rx_int_en` are both 1. A resume match that ends a suspension clears `xoff_flag`.
- R6: A resume match while the transmitter is not suspended leaves `tx_enable` at 1 and `xoff_flag` unchanged.
- R7: When `fifo_count` reaches `lvl_high` or more, `send_xoff` pulses for exactly one cycle. It does not pulse again until `fifo_count` has fallen to `lvl_low` or less, which produces one `send_xon` pulse. The two pulses are never high together.
- R8: A send request is issued only on a cycle after one in which `tx_active` was low. A crossing that happens during transmission is held until the character has finished.
- R9: With `sw_en`=0 no byte matches and no request is issued. One cycle after `sw_en` falls, `tx_enable` is 1 and `xoff_flag` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Character register write strobe |
| cfg_sel | input | 2 | Character register select (see R1) |
| cfg_wdata | input | 8 | Character register write data |
| sw_en | input | 1 | Software flow control enable |
| pair_mode | input | 1 | 1 = two-character matching |
| flag_en | input | 1 | Allows a stop match to set the flag |
| rx_int_en | input | 1 | Routes the flag to `irq` |
| rx_valid | input | 1 | Received byte strobe |
| rx_data | input | 8 | Received byte |
| fifo_count | input | CNT_W | Receive FIFO fill level |
| lvl_high | input | CNT_W | Fill level that triggers a stop request |
| lvl_low | input | CNT_W | Fill level that triggers a resume request |
| tx_active | input | 1 | A character is being shifted out |
| tx_enable | output | 1 | Transmitter may start a new character |
| send_xoff | output | 1 | One-cycle request to send the stop character |
| send_xon | output | 1 | One-cycle request to send the resume character |
| xoff_flag | output | 1 | Stop-received status flag |
| irq | output | 1 | Interrupt |

## Verification
The hardest state to reach is a pair-mode sequence that is broken or partly repeated. Examples are a first value followed by an unrelated byte, a second value with nothing before it, and a first value received twice before the second. The vector table walks through exactly these byte orders, and after every byte it checks `tx_enable` and the flag. A stop match that arrives while `tx_active` is high is held across several cycles before `tx_active` drops. A level crossing is also made during transmission, to show that the request waits for the character to finish.

// File: rtl/sfc_pkg.sv
package sfc_pkg;
  localparam int CHAR_W = 8;
  localparam int N_CHARS = 4;
  localparam int SEL_ON_A  = 0;
  localparam int SEL_ON_B  = 1;
  localparam int SEL_OFF_A = 2;
  localparam int SEL_OFF_B = 3;

  typedef logic [CHAR_W-1:0] char_t;
  typedef enum logic [1:0] {LV_LOW, LV_OFF_WAIT, LV_HIGH, LV_ON_WAIT} lvl_e;

  function automatic logic char_eq(input char_t a, input char_t b);
    return a == b;
  endfunction
endpackage

// File: rtl/sfc_char_regs.sv
module sfc_char_regs
  import sfc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic [1:0]               wr_sel,
  input  char_t                    wr_data,
  output logic [N_CHARS-1:0][CHAR_W-1:0] chars
);
  for (genvar g = 0; g < N_CHARS; g++) begin : g_reg
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                chars[g] <= '0;
      else if (wr_en && wr_sel == 2'(g))         chars[g] <= wr_data;
    end
  end
endmodule

// File: rtl/sfc_matcher.sv
module sfc_matcher
  import sfc_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     en,
  input  logic                     pair_mode,
  input  logic                     rx_valid,
  input  char_t                    rx_data,
  input  logic [N_CHARS-1:0][CHAR_W-1:0] chars,
  output logic                     xoff_hit,
  output logic                     xon_hit
);
  logic eq_off_a, eq_off_b, eq_on_a, eq_on_b;
  logic pend_off, pend_on;
  logic live_single, live_pair;

  assign eq_off_a = char_eq(rx_data, chars[SEL_OFF_A]);
  assign eq_off_b = char_eq(rx_data, chars[SEL_OFF_B]);
  assign eq_on_a  = char_eq(rx_data, chars[SEL_ON_A]);
  assign eq_on_b  = char_eq(rx_data, chars[SEL_ON_B]);

  assign live_single = rx_valid && en && !pair_mode;
  assign live_pair   = rx_valid && en &&  pair_mode;

  assign xoff_hit = (live_single && eq_off_a) || (live_pair && pend_off && eq_off_b);
  assign xon_hit  = (live_single && eq_on_a)  || (live_pair && pend_on  && eq_on_b);

  // first-of-pair tracking: each received byte either arms or disarms
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (!en || !pair_mode) begin
      pend_off <= 1'b0;
      pend_on  <= 1'b0;
    end else if (rx_valid) begin
      pend_off <= eq_off_a;
      pend_on  <= eq_on_a;
    end
  end
endmodule

// File: rtl/sfc_tx_gate.sv
module sfc_tx_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic xoff_hit,
  input  logic xon_hit,
  input  logic tx_active,
  input  logic flag_en,
  input  logic rx_int_en,
  output logic tx_enable,
  output logic xoff_flag,
  output logic irq
);
  logic halted, stop_pend, suspended;
  logic stop_event, resume_event;

  assign suspended    = halted || stop_pend;
  assign stop_event   = xoff_hit;
  assign resume_event = xon_hit && !xoff_hit && suspended;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      halted    <= 1'b0;
      stop_pend <= 1'b0;
      xoff_flag <= 1'b0;
    end else if (!en) begin
      halted    <= 1'b0;
      stop_pend <= 1'b0;
      xoff_flag <= 1'b0;
    end else if (stop_event) begin
      halted    <= halted || !tx_active;
      stop_pend <= !halted && tx_active;
      xoff_flag <= xoff_flag || flag_en;
    end else if (resume_event) begin
      halted    <= 1'b0;
      stop_pend <= 1'b0;
      xoff_flag <= 1'b0;
    end else if (stop_pend && !tx_active) begin
      halted    <= 1'b1;
      stop_pend <= 1'b0;
    end
  end

  assign tx_enable = !halted;
  assign irq       = xoff_flag && rx_int_en;

  p_halt_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(halted) |-> !$past(tx_active));

  p_resume_cause_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(halted) |-> ($past(xon_hit) || !$past(en)));

  p_flag_suspended_r5: assert property (@(posedge clk) disable iff (!rst_n)
    xoff_flag |-> suspended);
endmodule

// File: rtl/sfc_level.sv
module sfc_level
  import sfc_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             en,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] lvl_high,
  input  logic [CNT_W-1:0] lvl_low,
  input  logic             tx_active,
  output logic             send_xoff,
  output logic             send_xon
);
  function automatic logic at_high(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c >= t;
  endfunction

  function automatic logic at_low(input logic [CNT_W-1:0] c, input logic [CNT_W-1:0] t);
    return c <= t;
  endfunction

  lvl_e state;
  logic cross_up, cross_down;

  assign cross_up   = (state == LV_LOW)  && at_high(fifo_count, lvl_high);
  assign cross_down = (state == LV_HIGH) && at_low(fifo_count, lvl_low);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= LV_LOW;
      send_xoff <= 1'b0;
      send_xon  <= 1'b0;
    end else begin
      send_xoff <= 1'b0;
      send_xon  <= 1'b0;
      if (!en) begin
        state <= LV_LOW;
      end else begin
        unique case (state)
          LV_LOW:
            if (cross_up) begin
              if (!tx_active) begin
                state     <= LV_HIGH;
                send_xoff <= 1'b1;
              end else begin
                state <= LV_OFF_WAIT;
              end
            end
          LV_OFF_WAIT:
            if (!tx_active) begin
              state     <= LV_HIGH;
              send_xoff <= 1'b1;
            end
          LV_HIGH:
            if (cross_down) begin
              if (!tx_active) begin
                state    <= LV_LOW;
                send_xon <= 1'b1;
              end else begin
                state <= LV_ON_WAIT;
              end
            end
          LV_ON_WAIT:
            if (!tx_active) begin
              state    <= LV_LOW;
              send_xon <= 1'b1;
            end
          default: state <= LV_LOW;
        endcase
      end
    end
  end

  p_req_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (send_xoff || send_xon) |-> !$past(tx_active));

  p_single_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    send_xoff |=> !send_xoff);

  p_no_dual_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !(send_xoff && send_xon));
endmodule

// File: rtl/sfc_top.sv
module sfc_top
  import sfc_pkg::*;
#(
  parameter int FIFO_DEPTH = 128,
  localparam int CNT_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [1:0]       cfg_sel,
  input  logic [7:0]       cfg_wdata,
  input  logic             sw_en,
  input  logic             pair_mode,
  input  logic             flag_en,
  input  logic             rx_int_en,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic [CNT_W-1:0] fifo_count,
  input  logic [CNT_W-1:0] lvl_high,
  input  logic [CNT_W-1:0] lvl_low,
  input  logic             tx_active,
  output logic             tx_enable,
  output logic             send_xoff,
  output logic             send_xon,
  output logic             xoff_flag,
  output logic             irq
);
  logic [N_CHARS-1:0][CHAR_W-1:0] chars;
  logic xoff_hit, xon_hit;

  sfc_char_regs i_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(cfg_we), .wr_sel(cfg_sel),
    .wr_data(cfg_wdata), .chars(chars)
  );

  sfc_matcher i_match (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .pair_mode(pair_mode),
    .rx_valid(rx_valid), .rx_data(rx_data), .chars(chars),
    .xoff_hit(xoff_hit), .xon_hit(xon_hit)
  );

  sfc_tx_gate i_gate (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .xoff_hit(xoff_hit),
    .xon_hit(xon_hit), .tx_active(tx_active), .flag_en(flag_en),
    .rx_int_en(rx_int_en), .tx_enable(tx_enable), .xoff_flag(xoff_flag),
    .irq(irq)
  );

  sfc_level #(.CNT_W(CNT_W)) i_level (
    .clk(clk), .rst_n(rst_n), .en(sw_en), .fifo_count(fifo_count),
    .lvl_high(lvl_high), .lvl_low(lvl_low), .tx_active(tx_active),
    .send_xoff(send_xoff), .send_xon(send_xon)
  );

  p_disabled_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(sw_en) |-> (tx_enable && !xoff_flag && !send_xoff && !send_xon));

  p_hits_need_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(xoff_flag) |-> $past(rx_valid));
endmodule

// File: tb/test_sfc_top.sv
module test_sfc_top;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0;
  logic sw_en = 1'b0, pair_mode = 1'b0, flag_en = 1'b1, rx_int_en = 1'b1;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = '0;
  logic [CNT_W-1:0] fifo_count = '0, lvl_high = 8'd100, lvl_low = 8'd20;
  logic tx_active = 1'b0;
  logic tx_enable, send_xoff, send_xon, xoff_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sfc_top i_sfc_top (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .sw_en(sw_en), .pair_mode(pair_mode),
    .flag_en(flag_en), .rx_int_en(rx_int_en), .rx_valid(rx_valid),
    .rx_data(rx_data), .fifo_count(fifo_count), .lvl_high(lvl_high),
    .lvl_low(lvl_low), .tx_active(tx_active), .tx_enable(tx_enable),
    .send_xoff(send_xoff), .send_xon(send_xon), .xoff_flag(xoff_flag),
    .irq(irq)
  );

  // {pair_mode, byte, expected tx_enable, expected xoff_flag}
  localparam logic [10:0] VEC [0:21] = '{
    {1'b0, 8'h41, 1'b1, 1'b0}, {1'b0, 8'h11, 1'b1, 1'b0},
    {1'b0, 8'h13, 1'b0, 1'b1}, {1'b0, 8'h13, 1'b0, 1'b1},
    {1'b0, 8'h42, 1'b0, 1'b1}, {1'b0, 8'h11, 1'b1, 1'b0},
    {1'b1, 8'h13, 1'b1, 1'b0}, {1'b1, 8'h14, 1'b0, 1'b1},
    {1'b1, 8'h11, 1'b0, 1'b1}, {1'b1, 8'h41, 1'b0, 1'b1},
    {1'b1, 8'h12, 1'b0, 1'b1}, {1'b1, 8'h11, 1'b0, 1'b1},
    {1'b1, 8'h12, 1'b1, 1'b0}, {1'b1, 8'h14, 1'b1, 1'b0},
    {1'b1, 8'h13, 1'b1, 1'b0}, {1'b1, 8'h55, 1'b1, 1'b0},
    {1'b1, 8'h14, 1'b1, 1'b0}, {1'b1, 8'h13, 1'b1, 1'b0},
    {1'b1, 8'h13, 1'b1, 1'b0}, {1'b1, 8'h14, 1'b0, 1'b1},
    {1'b1, 8'h11, 1'b0, 1'b1}, {1'b1, 8'h12, 1'b1, 1'b0}
  };

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wr_char(input logic [1:0] sel, input logic [7:0] val);
    @(negedge clk);
    cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = val;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  // byte is taken at the next posedge; results are sampled at the negedge after it
  task automatic rx_byte(input logic [7:0] b);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = b;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("reset tx_enable", int'(tx_enable), 1);
    chk("reset xoff_flag", int'(xoff_flag), 0);
    chk("reset send pulses", int'(send_xoff | send_xon), 0);

    // R1: all characters zero after reset, so 0x00 is a stop char (stop wins over resume 0x00)
    sw_en = 1'b1;
    rx_byte(8'h00);
    chk("R1 zero char stops", int'(tx_enable), 0);
    wr_char(2'd0, 8'h11);
    wr_char(2'd1, 8'h12);
    wr_char(2'd2, 8'h13);
    wr_char(2'd3, 8'h14);
    rx_byte(8'h11);
    chk("R1 written resume char", int'(tx_enable), 1);
    chk("R5 flag cleared", int'(xoff_flag), 0);

    // R2 R4 R5 R6: vector walk
    for (int i = 0; i < 22; i++) begin
      @(negedge clk);
      pair_mode = VEC[i][10];
      rx_valid = 1'b1; rx_data = VEC[i][9:2];
      @(negedge clk);
      rx_valid = 1'b0;
      chk($sformatf("R2/R4/R6 vec %0d tx_enable", i), int'(tx_enable), int'(VEC[i][1]));
      chk($sformatf("R5 vec %0d flag", i), int'(xoff_flag), int'(VEC[i][0]));
      chk($sformatf("R5 vec %0d irq", i), int'(irq), int'(VEC[i][0]));
    end
    pair_mode = 1'b0;

    // R3: stop during transmission waits for character end
    @(negedge clk); tx_active = 1'b1;
    rx_byte(8'h13);
    chk("R3 held while active", int'(tx_enable), 1);
    repeat (3) @(negedge clk);
    chk("R3 still held", int'(tx_enable), 1);
    chk("R5 flag set at match", int'(xoff_flag), 1);
    tx_active = 1'b0;
    @(negedge clk);
    chk("R3 halted after char end", int'(tx_enable), 0);
    rx_byte(8'h11);
    chk("R2 resumed", int'(tx_enable), 1);

    // R5: flag gating and interrupt gating
    flag_en = 1'b0;
    rx_byte(8'h13);
    chk("R5 halted without flag", int'(tx_enable), 0);
    chk("R5 flag not set", int'(xoff_flag), 0);
    rx_byte(8'h11);
    flag_en = 1'b1; rx_int_en = 1'b0;
    rx_byte(8'h13);
    chk("R5 flag set", int'(xoff_flag), 1);
    chk("R5 irq masked", int'(irq), 0);
    rx_int_en = 1'b1;
    @(negedge clk);
    chk("R5 irq unmasked", int'(irq), 1);

    // R9: disabling clears suspension, and matching stops
    sw_en = 1'b0;
    @(negedge clk);
    chk("R9 tx_enable on disable", int'(tx_enable), 1);
    chk("R9 flag cleared on disable", int'(xoff_flag), 0);
    rx_byte(8'h13);
    chk("R9 no match when disabled", int'(tx_enable), 1);
    fifo_count = 8'd120;
    repeat (2) @(negedge clk);
    chk("R9 no request when disabled", int'(send_xoff), 0);
    fifo_count = 8'd50;
    sw_en = 1'b1;

    // R7: level hysteresis
    repeat (2) @(negedge clk);
    chk("R7 no request mid level", int'(send_xoff | send_xon), 0);
    fifo_count = 8'd100;
    @(negedge clk);
    chk("R7 xoff pulse", int'(send_xoff), 1);
    @(negedge clk);
    chk("R7 xoff single cycle", int'(send_xoff), 0);
    fifo_count = 8'd110;
    repeat (3) @(negedge clk);
    chk("R7 no repeat above", int'(send_xoff), 0);
    fifo_count = 8'd21;
    @(negedge clk);
    chk("R7 no xon above low", int'(send_xon), 0);
    fifo_count = 8'd20;
    @(negedge clk);
    chk("R7 xon pulse", int'(send_xon), 1);
    @(negedge clk);
    chk("R7 xon single cycle", int'(send_xon), 0);

    // R8: crossing during transmission is deferred
    tx_active = 1'b1;
    fifo_count = 8'd128;
    repeat (3) @(negedge clk);
    chk("R8 xoff deferred", int'(send_xoff), 0);
    tx_active = 1'b0;
    @(negedge clk);
    chk("R8 xoff after char end", int'(send_xoff), 1);
    @(negedge clk);
    tx_active = 1'b1;
    fifo_count = 8'd5;
    repeat (2) @(negedge clk);
    chk("R8 xon deferred", int'(send_xon), 0);
    tx_active = 1'b0;
    @(negedge clk);
    chk("R8 xon after char end", int'(send_xon), 1);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule